// File: doc/BRIEF.md
# Three-Wire Configuration Register Slave

This block takes configuration words from a three-wire serial bus made of a bus clock, a data line and an active-low enable. The three bus lines are asynchronous to the block's own system clock. The block synchronizes all three and oversamples them with that faster clock. While the enable is low, each rising edge of the bus clock shifts one data bit into a shift register, MSB first. When the enable returns high, the block classifies the collected word, decodes its fields into an active configuration and pulses a one-cycle update strobe for downstream logic.

Three word formats are recognised by their header bits:
- **Transmit word (16 bits):** carries the power ramp level, the deviation scale and the synthesizer fields.
- **Plain receive word (16 bits):** carries only the synthesizer fields.
- **Clock-recovery receive word (25 bits):** a plain receive word preceded by a fixed 9-bit prefix.

The block does not check how many bus clocks arrived. Only the most recent 25 bits are kept, and any earlier bits fall away. Words that do not fit a format are dropped, and the active configuration is left as it was.

Top module: `cfg3w_slave`

## Requirements
- R1: After reset the outputs hold these values:
  - mode = 0 (plain receive); all field codes 0; ramp_mv = 1300; dev_pct = 60; main_div = 86; chan_n = 2752; cfg_valid low.
- R2: A bit is taken only on a rising bus_clk edge while bus_en_n is low. Bus clock edges while bus_en_n is high change nothing: no cfg_valid pulse and no output change.
- R3: Configuration outputs change only on the rising edge of bus_en_n. They change together with a cfg_valid pulse that is exactly one system clock long, and they hold their values at all other times.
- R4: When more bits arrive than a format needs, the earlier bits are discarded. Only the last 25 bits are kept, and the last 16 of those form the low word.
- R5: A 16-bit word is a transmit word when bits 15:14 = 01 and bit 8 = 1. It sets mode = 1 and updates these fields:
  - ramp code from bits 13:12
  - deviation code from bits 11:9
  - reference select from bit 7
  - main counter code from bits 6:5
  - swallow count from bits 4:0
- R6: A word with bits 15:14 = 00 is a plain receive word. It sets mode = 0, takes the reference, main and swallow fields from bits 7:0, and leaves the ramp and deviation codes unchanged.
- R7: If at least 25 bits arrived, bits 24:16 equal 1_0100_0000 and bits 15:14 = 00, the word sets mode = 2 (receive with clock recovery) and uses the same low-byte fields as R6.
- R8: A word of 25 or more bits whose bits 24:16 do not match that prefix is decoded from its low 16 bits alone, exactly as in R5 and R6.
- R9: A word is rejected if any of these holds: fewer than 16 bits arrived, bits 15:14 = 1x, or bits 15:14 = 01 with bit 8 = 0. A rejected word produces no cfg_valid pulse and leaves every output unchanged.
- R10: The deviation and ramp codes map to physical values:
  - dev_pct = 60 + 10 × deviation code
  - ramp code 0, 1, 2, 3 gives ramp_mv = 1300, 1350, 1400, 1750
- R11: main_div = 86 + main counter code, and chan_n = 32 × main_div + swallow count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bus clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_clk | input | 1 | Serial bus clock (asynchronous) |
| bus_data | input | 1 | Serial bus data, MSB first (asynchronous) |
| bus_en_n | input | 1 | Serial bus enable, active low (asynchronous) |
| cfg_valid | output | 1 | One-cycle strobe when a new configuration becomes active |
| mode | output | 2 | 0 receive, 1 transmit, 2 receive with clock recovery |
| ramp_code | output | 2 | Power ramp level code |
| ramp_mv | output | 11 | Ramp level in millivolts |
| dev_code | output | 3 | Deviation scale code |
| dev_pct | output | 8 | Deviation scale in percent |
| ref_sel | output | 1 | Reference clock select |
| main_div | output | 7 | Main counter divide value (86 to 89) |
| swallow | output | 5 | Swallow count |
| chan_n | output | 12 | Total synthesizer divide value |

## Verification
A rising edge of bus_en_n at the pins passes through a two-flop synchronizer and an edge register. The outputs and cfg_valid therefore change on the third system clock edge after the edge is driven, and cfg_valid drops one edge later. A data bit likewise lands in the shift register on the third edge after its bus clock rise. The bench sends each data bit two cycles before the bus clock rise and holds every bus level for at least three system clocks. After each enable rise it waits eight system clocks, which covers the three-cycle latency. It then compares every output field and checks the number of cfg_valid pulses counted on falling system clock edges, which must be one for an accepted word and zero for a rejected one.

// File: rtl/cfg3w_pkg.sv
// Shared types and value mappings for the three-wire configuration slave.
package cfg3w_pkg;

    typedef enum logic [1:0] {
        MODE_RX   = 2'd0,
        MODE_TX   = 2'd1,
        MODE_RXCR = 2'd2
    } cfg_mode_e;

    typedef struct packed {
        cfg_mode_e   mode;
        logic [1:0]  ramp;
        logic [2:0]  dev;
        logic        ref_sel;
        logic [1:0]  mc;
        logic [4:0]  sc;
    } cfg_fields_t;

    // Deviation scale in percent: 60 % plus 10 % per code step.
    function automatic logic [7:0] dev_to_pct(input logic [2:0] code);
        return 8'd60 + 8'd10 * {5'd0, code};
    endfunction

    // Ramp level in millivolts for each ramp code.
    function automatic logic [10:0] ramp_to_mv(input logic [1:0] code);
        logic [10:0] mv;
        case (code)
            2'd0:    mv = 11'd1300;
            2'd1:    mv = 11'd1350;
            2'd2:    mv = 11'd1400;
            default: mv = 11'd1750;
        endcase
        return mv;
    endfunction

endpackage

// File: rtl/cfg3w_sync.sv
// Multi-bit synchronizer with edge detection.
// Each input bit gets its own flop chain, so the bits are not kept
// coherent with each other. Rise and fall strobes are one system clock
// wide and appear when the synchronized level changes.
// Assumes every input holds each level for at least STAGES+1 system clocks.
module cfg3w_sync #(
    parameter int            N_SIG   = 3,
    parameter int            STAGES  = 2,
    parameter logic [N_SIG-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] async_in,
    output logic [N_SIG-1:0] sync_out,
    output logic [N_SIG-1:0] rise,
    output logic [N_SIG-1:0] fall
);

    for (genvar g = 0; g < N_SIG; g++) begin : g_sig
        logic [STAGES-1:0] chain;
        logic              last;

        // Shift the raw level through the chain and keep the previous synced value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[g]}};
                last  <= RST_VAL[g];
            end else begin
                chain <= {chain[STAGES-2:0], async_in[g]};
                last  <= chain[STAGES-1];
            end
        end

        assign sync_out[g] = chain[STAGES-1];
        assign rise[g]     = chain[STAGES-1] & ~last;
        assign fall[g]     = ~chain[STAGES-1] & last;
    end

endmodule

// File: rtl/cfg3w_shift.sv
// Serial capture register. A clear empties the register and the counter.
// Each shift strobe moves one bit in at the LSB, so the first bit sent
// ends up as the MSB. The counter saturates at LONG_W, so only the last
// LONG_W bits survive.
module cfg3w_shift #(
    parameter int LONG_W = 25,
    localparam int CNT_W = $clog2(LONG_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [LONG_W-1:0] word,
    output logic [CNT_W-1:0]  count
);

    // Capture bits and count them up to the saturation limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            word  <= '0;
            count <= '0;
        end else if (shift_en) begin
            word <= {word[LONG_W-2:0], bit_in};
            if (count != CNT_W'(LONG_W)) begin
                count <= count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfg3w_decode.sv
// Word classifier and active configuration register.
// On a latch strobe the captured word is sorted into transmit, plain
// receive, clock-recovery receive or reject. Accepted words update the
// held fields and raise a one-cycle valid strobe. Ramp and deviation
// fields change only on transmit words.
module cfg3w_decode
    import cfg3w_pkg::*;
#(
    parameter int         SHORT_W = 16,
    parameter int         LONG_W  = 25,
    parameter logic [8:0] CR_HDR  = 9'b1_0100_0000,
    localparam int        CNT_W   = $clog2(LONG_W + 1),
    localparam int        HDR_W   = LONG_W - SHORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch,
    input  logic [LONG_W-1:0] word,
    input  logic [CNT_W-1:0]  count,
    output cfg_fields_t       cfg,
    output logic              valid
);

    localparam int TYPE_HI = SHORT_W - 1;
    localparam int TYPE_LO = SHORT_W - 2;
    localparam int MARK_B  = 8;

    logic [SHORT_W-1:0] low;
    logic               long_ok;
    logic               accept;
    cfg_mode_e          new_mode;

    assign low     = word[SHORT_W-1:0];
    assign long_ok = (count >= CNT_W'(LONG_W)) &&
                     (word[LONG_W-1:SHORT_W] == HDR_W'(CR_HDR));

    // Sort the captured word into a mode or a reject.
    always_comb begin
        accept   = 1'b0;
        new_mode = MODE_RX;
        if (count >= CNT_W'(SHORT_W)) begin
            unique case (low[TYPE_HI:TYPE_LO])
                2'b00: begin
                    accept   = 1'b1;
                    new_mode = long_ok ? MODE_RXCR : MODE_RX;
                end
                2'b01: begin
                    accept   = low[MARK_B];
                    new_mode = MODE_TX;
                end
                default: begin
                    accept   = 1'b0;
                    new_mode = MODE_RX;
                end
            endcase
        end
    end

    // Hold the active configuration and pulse valid on an accepted latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg   <= '{mode: MODE_RX, default: '0};
            valid <= 1'b0;
        end else begin
            valid <= latch && accept;
            if (latch && accept) begin
                cfg.mode    <= new_mode;
                cfg.ref_sel <= low[7];
                cfg.mc      <= low[6:5];
                cfg.sc      <= low[4:0];
                if (new_mode == MODE_TX) begin
                    cfg.ramp <= low[13:12];
                    cfg.dev  <= low[11:9];
                end
            end
        end
    end

endmodule

// File: rtl/cfg3w_slave.sv
// Top of the three-wire configuration slave.
// The asynchronous bus lines are synchronized, bits are captured while
// enable is low, and the word is decoded when enable rises. The system
// clock must run at four or more times the bus clock, and each bus level
// must hold for at least three system clocks.
module cfg3w_slave
    import cfg3w_pkg::*;
#(
    parameter int SHORT_W = 16,
    parameter int LONG_W  = 25,
    parameter int STAGES  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_clk,
    input  logic        bus_data,
    input  logic        bus_en_n,
    output logic        cfg_valid,
    output logic [1:0]  mode,
    output logic [1:0]  ramp_code,
    output logic [10:0] ramp_mv,
    output logic [2:0]  dev_code,
    output logic [7:0]  dev_pct,
    output logic        ref_sel,
    output logic [6:0]  main_div,
    output logic [4:0]  swallow,
    output logic [11:0] chan_n
);

    localparam int CNT_W  = $clog2(LONG_W + 1);
    localparam int I_CLK  = 0;
    localparam int I_DATA = 1;
    localparam int I_EN   = 2;

    logic [2:0]        s_lvl, s_rise, s_fall;
    logic [LONG_W-1:0] cap_word;
    logic [CNT_W-1:0]  cap_cnt;
    cfg_fields_t       cfg;

    cfg3w_sync #(
        .N_SIG   (3),
        .STAGES  (STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({bus_en_n, bus_data, bus_clk}),
        .sync_out (s_lvl),
        .rise     (s_rise),
        .fall     (s_fall)
    );

    cfg3w_shift #(
        .LONG_W (LONG_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (s_fall[I_EN]),
        .shift_en (s_rise[I_CLK] && !s_lvl[I_EN]),
        .bit_in   (s_lvl[I_DATA]),
        .word     (cap_word),
        .count    (cap_cnt)
    );

    cfg3w_decode #(
        .SHORT_W (SHORT_W),
        .LONG_W  (LONG_W)
    ) u_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .latch (s_rise[I_EN]),
        .word  (cap_word),
        .count (cap_cnt),
        .cfg   (cfg),
        .valid (cfg_valid)
    );

    // Expand the held codes into physical values.
    always_comb begin
        mode      = cfg.mode;
        ramp_code = cfg.ramp;
        ramp_mv   = ramp_to_mv(cfg.ramp);
        dev_code  = cfg.dev;
        dev_pct   = dev_to_pct(cfg.dev);
        ref_sel   = cfg.ref_sel;
        main_div  = 7'd86 + {5'd0, cfg.mc};
        swallow   = cfg.sc;
        chan_n    = {main_div, 5'd0} + {7'd0, cfg.sc};
    end

endmodule

// File: rtl/cfg3w_checker.sv
// Property checker for the three-wire configuration slave, bound to the top.
module cfg3w_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_valid,
    input logic [1:0]  mode,
    input logic [1:0]  ramp_code,
    input logic [2:0]  dev_code,
    input logic        ref_sel,
    input logic [4:0]  swallow,
    input logic [6:0]  main_div
);

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> !cfg_valid);  // R3

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |=> ($stable(mode) && $stable(ramp_code) && $stable(dev_code) &&
                        $stable(ref_sel) && $stable(swallow) && $stable(main_div)) || cfg_valid);  // R3

    AST_RX_KEEPS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && mode != 2'd1) |-> ($stable(ramp_code) && $stable(dev_code)));  // R6

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'd3);  // R7

endmodule

bind cfg3w_slave cfg3w_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .mode      (mode),
    .ramp_code (ramp_code),
    .dev_code  (dev_code),
    .ref_sel   (ref_sel),
    .swallow   (swallow),
    .main_div  (main_div)
);

// File: tb/cfg3w_slave_bench.sv
module cfg3w_slave_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_clk = 1'b0;
    logic        bus_data = 1'b0;
    logic        bus_en_n = 1'b1;
    logic        cfg_valid;
    logic [1:0]  mode, ramp_code;
    logic [10:0] ramp_mv;
    logic [2:0]  dev_code;
    logic [7:0]  dev_pct;
    logic        ref_sel;
    logic [6:0]  main_div;
    logic [4:0]  swallow;
    logic [11:0] chan_n;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done = 0;

    // Expected state
    int e_mode = 0, e_ramp = 0, e_dev = 0, e_ref = 0, e_mc = 0, e_sc = 0;

    always #5 clk = ~clk;

    cfg3w_slave u_cfg3w_slave (
        .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_data(bus_data),
        .bus_en_n(bus_en_n), .cfg_valid(cfg_valid), .mode(mode),
        .ramp_code(ramp_code), .ramp_mv(ramp_mv), .dev_code(dev_code),
        .dev_pct(dev_pct), .ref_sel(ref_sel), .main_div(main_div),
        .swallow(swallow), .chan_n(chan_n)
    );

    always @(negedge clk) if (cfg_valid) pulses++;

    function automatic int exp_mv(input int c);
        case (c)
            0: return 1300;
            1: return 1350;
            2: return 1400;
            default: return 1750;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "mode", int'(mode), e_mode);
        chk(tag, "ramp_code", int'(ramp_code), e_ramp);
        chk(tag, "dev_code", int'(dev_code), e_dev);
        chk(tag, "ref_sel", int'(ref_sel), e_ref);
        chk(tag, "swallow", int'(swallow), e_sc);
        chk("R10", "ramp_mv", int'(ramp_mv), exp_mv(e_ramp));
        chk("R10", "dev_pct", int'(dev_pct), 60 + 10 * e_dev);
        chk("R11", "main_div", int'(main_div), 86 + e_mc);
        chk("R11", "chan_n", int'(chan_n), 32 * (86 + e_mc) + e_sc);
    endtask

    // Bench model of the classification rules.
    task automatic model(input logic [31:0] bits, input int n, output string tag, output bit acc);
        logic [24:0] kept;
        logic [15:0] low;
        int cnt;
        cnt  = (n >= 25) ? 25 : n;
        kept = (n >= 25) ? bits[24:0] : 25'(bits & ((32'd1 << n) - 1));
        low  = kept[15:0];
        acc  = 1'b0;
        tag  = "R9";
        if (cnt >= 16) begin
            if (low[15:14] == 2'b00) begin
                acc = 1'b1;
                if (cnt >= 25 && kept[24:16] == 9'h140) begin
                    e_mode = 2; tag = "R7";
                end else begin
                    e_mode = 0; tag = (cnt >= 25) ? "R8" : "R6";
                end
            end else if (low[15:14] == 2'b01 && low[8]) begin
                acc = 1'b1; e_mode = 1;
                e_ramp = int'(low[13:12]);
                e_dev  = int'(low[11:9]);
                tag = (cnt >= 25) ? "R8" : "R5";
            end
        end
        if (acc) begin
            e_ref = int'(low[7]);
            e_mc  = int'(low[6:5]);
            e_sc  = int'(low[4:0]);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) bus_data = b;
        repeat (2) @(negedge clk);
        bus_clk = 1'b1;
        repeat (3) @(negedge clk);
        bus_clk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_word(input logic [31:0] bits, input int n, input string force_tag);
        string tag;
        bit acc;
        int p0;
        model(bits, n, tag, acc);
        if (force_tag != "") tag = force_tag;
        @(negedge clk) bus_en_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) send_bit(bits[i]);
        repeat (3) @(negedge clk);
        p0 = pulses;
        bus_en_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(acc ? "R3" : "R9", "valid_pulses", pulses - p0, acc ? 1 : 0);
        check_all(tag);
    endtask

    initial begin
        int p0;
        logic [31:0] w;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "cfg_valid", int'(cfg_valid), 0);
        chk("R1", "pulses", pulses, 0);
        check_all("R1");

        // R5 transmit word
        do_word(32'b01_11_101_1_1_10_10101, 16, "R5");
        // R6 receive keeps ramp and deviation
        do_word(32'b00_00_000_0_0_01_00110, 16, "R6");
        // R7 clock-recovery word
        do_word({7'd0, 9'b1_0100_0000, 16'b00_10_110_1_1_11_11111}, 25, "R7");
        // R8 long word with a wrong prefix, transmit low half
        do_word({7'd0, 9'b1_0100_0001, 16'b01_01_010_1_0_00_00011}, 25, "R8");
        // R8 long word with a wrong prefix, receive low half
        do_word({7'd0, 9'b0_0100_0000, 16'b00_11_111_1_1_01_01010}, 25, "R8");
        // R4 leading junk ahead of a transmit word
        do_word({11'b101_1010_1101, 16'b01_10_011_1_0_11_01100}, 27, "R4");
        // R4 leading junk ahead of a 16-bit receive word, 20 bits total
        do_word({12'd0, 4'b1111, 16'b00_00_000_0_1_00_00001}, 20, "R4");
        // R9 rejects
        do_word(32'h3FF, 10, "R9");
        do_word(32'b11_00_000_1_0_00_00000, 16, "R9");
        do_word(32'b01_11_111_0_1_11_11111, 16, "R9");
        do_word(32'b10_11_111_1_1_11_11111, 16, "R9");

        // R2 bus clocks with enable high are ignored
        p0 = pulses;
        for (int k = 0; k < 6; k++) send_bit(k[0]);
        repeat (8) @(negedge clk);
        chk("R2", "stray_pulses", pulses - p0, 0);
        check_all("R2");

        // R10 every deviation and ramp code
        for (int d = 0; d < 8; d++) begin
            w = {16'd0, 2'b01, 2'(d % 4), 3'(d), 1'b1, 1'b0, 2'(d % 4), 5'(d)};
            do_word(w, 16, "R10");
        end

        // Random words
        for (int t = 0; t < 40; t++) begin
            int n;
            n = 12 + int'($urandom % 19);
            w = $urandom;
            case ($urandom % 4)
                0: w[15:14] = 2'b00;
                1: w[15:14] = 2'b01;
                2: begin w[15:14] = 2'b01; w[8] = 1'b1; end
                default: ;
            endcase
            if ($urandom % 3 == 0) begin
                w[24:16] = 9'h140;
                w[15:14] = 2'b00;
            end
            do_word(w, n, "");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule